// File: doc/BRIEF.md
# Cache-Maintenance Serialization Gate

This block sits between a load/store issue queue and the memory pipeline and makes cache-maintenance operations run strictly one at a time. Each cycle it sees at most one issue request, tagged with an operation class, and answers at once with a grant. It keeps separate counts of outstanding loads, outstanding stores and writebacks still in flight to the external agent. These counts decide when the active cache-maintenance operation may graduate.

While a cache-maintenance operation is active, the gate refuses every load, every store and any second maintenance operation. Uncached accesses and instruction fetches always pass. The active operation may graduate only when it has signalled its own completion and all three counts are zero. Graduation is a single-cycle indication, and the gate clears its active marker on the following edge. A pipeline flush drops the marker and the load/store counts, but it keeps the writeback count, because writebacks already sent to the external agent still have to drain.

Top module: `cop_serial_gate`

## Requirements
- R1: After reset no maintenance operation is active, `gradAllowed` is 0, all counts are zero, and a load request is granted in the first cycle.
- R2: A maintenance request (`reqType` = 2) is granted only when no maintenance operation is active. The marker is set on the edge that ends the grant cycle, and a second maintenance request is refused until then.
- R3: While the marker is set, load (`reqType` = 0) and store (`reqType` = 1) requests are refused in the same cycle.
- R4: Uncached (`reqType` = 3) and instruction-fetch (`reqType` = 4) requests are always granted in the same cycle, including while the marker is set and during a flush.
- R5: `gradAllowed` is 1 exactly when the marker is set, a `copDone` pulse has been seen since the maintenance operation started, and the load, store and writeback counts are all zero.
- R6: A granted load or store raises its count, and `ldDone`/`stDone` lowers it. `wbStart` raises the writeback count and `wbDone` lowers it. Graduation waits on each of these counts.
- R7: An increment and a decrement of the same count in the same cycle leave that count unchanged.
- R8: Counts saturate. A decrement at zero is ignored, a `wbStart` at the maximum (2^CNT_W-1) is ignored, and a load or store request is refused while its own count is at the maximum.
- R9: `flush` clears the marker, the seen-completion flag and the load and store counts on its edge, and keeps the writeback count. In the flush cycle it refuses load, store and maintenance requests.
- R10: The marker clears on the edge after `gradAllowed` is 1. A `copDone` pulse that arrives while no maintenance operation is active has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Issue request present this cycle |
| reqType | input | 3 | Class: 0 load, 1 store, 2 cache maintenance, 3 uncached, 4 instruction fetch |
| reqGrant | output | 1 | Request accepted this cycle |
| ldDone | input | 1 | One outstanding load completed |
| stDone | input | 1 | One outstanding store completed |
| wbStart | input | 1 | A writeback to the external agent was launched |
| wbDone | input | 1 | A writeback to the external agent finished |
| copDone | input | 1 | The active maintenance operation finished its own work |
| flush | input | 1 | Pipeline flush |
| gradAllowed | output | 1 | The active maintenance operation graduates this cycle |

## Verification
The bench builds the gate with CNT_W = 2, so every count saturates at 3. This makes the refused fourth load, the ignored fourth writeback launch and the ignored decrement at zero reachable in a few cycles. A counter that wraps instead of saturating then shows up as a graduation that comes too early or never comes. The same small width also lets a flush with a writeback still in flight be followed through to graduation quickly.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_CACHE  = 3'd2,
    OP_UNCACH = 3'd3,
    OP_IFETCH = 3'd4
  } op_kind_e;

  localparam int NUM_CNT = 3;
  localparam int IDX_LD  = 0;
  localparam int IDX_ST  = 1;
  localparam int IDX_WB  = 2;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic ldInc;
    logic stInc;
    logic lsClr;
  } gate_strobe_t;

endpackage

// File: rtl/cop_gate_dp.sv
module cop_gate_dp
  import cop_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gate_strobe_t     strobe,
  input  logic             ldDone,
  input  logic             stDone,
  input  logic             wbStart,
  input  logic             wbDone,
  output logic [CNT_W-1:0] ldCnt,
  output logic [CNT_W-1:0] stCnt,
  output logic [CNT_W-1:0] wbCnt,
  output logic             ldFull,
  output logic             stFull,
  output logic             allZero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic [NUM_CNT-1:0] incVec, decVec, clrVec;

  assign incVec = {wbStart, strobe.stInc, strobe.ldInc};
  assign decVec = {wbDone, stDone, ldDone};
  assign clrVec = {1'b0, strobe.lsClr, strobe.lsClr};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic doInc, doDec;
    assign doInc = incVec[g] && (cnt[g] != CNT_MAX);
    assign doDec = decVec[g] && (cnt[g] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n || clrVec[g]) begin
        cnt[g] <= '0;
      end else if (doInc && !decVec[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
      end else if (doDec && !incVec[g]) begin
        cnt[g] <= cnt[g] - 1'b1;
      end
    end
  end

  assign ldCnt   = cnt[IDX_LD];
  assign stCnt   = cnt[IDX_ST];
  assign wbCnt   = cnt[IDX_WB];
  assign ldFull  = (cnt[IDX_LD] == CNT_MAX);
  assign stFull  = (cnt[IDX_ST] == CNT_MAX);
  assign allZero = (cnt[IDX_LD] == '0) && (cnt[IDX_ST] == '0) && (cnt[IDX_WB] == '0);

endmodule

// File: rtl/cop_gate_ctrl.sv
module cop_gate_ctrl
  import cop_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic [2:0]   reqType,
  input  logic         copDone,
  input  logic         flush,
  input  logic         ldFull,
  input  logic         stFull,
  input  logic         allZero,
  output logic         reqGrant,
  output logic         gradAllowed,
  output logic         copActive,
  output gate_strobe_t strobe
);

  op_kind_e kind;
  logic     copDoneSeen;
  logic     grantLd, grantSt, grantCop, grantPass;

  assign kind = op_kind_e'(reqType);

  always_comb begin
    grantLd   = 1'b0;
    grantSt   = 1'b0;
    grantCop  = 1'b0;
    grantPass = 1'b0;
    if (reqValid) begin
      unique case (kind)
        OP_LOAD:   grantLd   = !copActive && !flush && !ldFull;
        OP_STORE:  grantSt   = !copActive && !flush && !stFull;
        OP_CACHE:  grantCop  = !copActive && !flush;
        OP_UNCACH,
        OP_IFETCH: grantPass = 1'b1;
        default:   grantPass = 1'b0;
      endcase
    end
  end

  assign reqGrant    = grantLd || grantSt || grantCop || grantPass;
  assign gradAllowed = copActive && copDoneSeen && allZero;

  assign strobe.ldInc = grantLd;
  assign strobe.stInc = grantSt;
  assign strobe.lsClr = flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || gradAllowed) begin
      copActive   <= 1'b0;
      copDoneSeen <= 1'b0;
    end else begin
      if (grantCop)             copActive   <= 1'b1;
      if (copActive && copDone) copDoneSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/cop_serial_gate.sv
module cop_serial_gate
  import cop_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqType,
  output logic       reqGrant,
  input  logic       ldDone,
  input  logic       stDone,
  input  logic       wbStart,
  input  logic       wbDone,
  input  logic       copDone,
  input  logic       flush,
  output logic       gradAllowed
);

  gate_strobe_t     strobe;
  logic             copActive;
  logic             ldFull, stFull, allZero;
  logic [CNT_W-1:0] ldCnt, stCnt, wbCnt;

  cop_gate_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqType(reqType),
    .copDone(copDone), .flush(flush), .ldFull(ldFull), .stFull(stFull),
    .allZero(allZero), .reqGrant(reqGrant), .gradAllowed(gradAllowed),
    .copActive(copActive), .strobe(strobe)
  );

  cop_gate_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ldDone(ldDone),
    .stDone(stDone), .wbStart(wbStart), .wbDone(wbDone),
    .ldCnt(ldCnt), .stCnt(stCnt), .wbCnt(wbCnt),
    .ldFull(ldFull), .stFull(stFull), .allZero(allZero)
  );

endmodule

// File: rtl/cop_gate_chk.sv
module cop_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic [2:0]       reqType,
  input logic             reqGrant,
  input logic             flush,
  input logic             wbStart,
  input logic             wbDone,
  input logic             gradAllowed,
  input logic             copActive,
  input logic [CNT_W-1:0] ldCnt,
  input logic [CNT_W-1:0] stCnt,
  input logic [CNT_W-1:0] wbCnt
);

  AST_COP_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (copActive && reqValid && reqType == 3'd2) |-> !reqGrant); // R2

  AST_LS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (copActive && reqValid && (reqType == 3'd0 || reqType == 3'd1)) |-> !reqGrant); // R3

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (reqType == 3'd3 || reqType == 3'd4)) |-> reqGrant); // R4

  AST_GRAD_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    gradAllowed |-> (copActive && ldCnt == '0 && stCnt == '0 && wbCnt == '0)); // R5

  AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wbCnt == '0 && !wbStart) |=> (wbCnt == '0)); // R8

  AST_FLUSH_KEEPS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wbStart && !wbDone) |=> $stable(wbCnt)); // R9

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!copActive && ldCnt == '0 && stCnt == '0)); // R9

  AST_GRAD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    gradAllowed |=> !copActive); // R10

endmodule

bind cop_serial_gate cop_gate_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_cop_serial_gate.sv
`timescale 1ns/1ps
module test_cop_serial_gate;

  localparam int CNT_W = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqType = 3'd0;
  logic       ldDone = 1'b0, stDone = 1'b0, wbStart = 1'b0, wbDone = 1'b0;
  logic       copDone = 1'b0, flush = 1'b0;
  logic       reqGrant, gradAllowed;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cop_serial_gate #(.CNT_W(CNT_W)) i_cop_serial_gate (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqType(reqType),
    .reqGrant(reqGrant), .ldDone(ldDone), .stDone(stDone),
    .wbStart(wbStart), .wbDone(wbDone), .copDone(copDone),
    .flush(flush), .gradAllowed(gradAllowed)
  );

  // vector: {valid, type[2:0], ldDone, stDone, wbStart, wbDone, copDone, flush, expGrant, expGrad}
  localparam int NVEC = 25;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 6'b000000, 2'b10}, // 0  R1 first load granted
    {1'b1, 3'd1, 6'b000000, 2'b10}, // 1  R6 store granted
    {1'b1, 3'd2, 6'b000000, 2'b10}, // 2  R2 maintenance granted
    {1'b1, 3'd0, 6'b000000, 2'b00}, // 3  R3 load refused
    {1'b1, 3'd2, 6'b000000, 2'b00}, // 4  R2 second maintenance refused
    {1'b1, 3'd3, 6'b000000, 2'b10}, // 5  R4 uncached passes
    {1'b1, 3'd4, 6'b000000, 2'b10}, // 6  R4 fetch passes
    {1'b0, 3'd0, 6'b000010, 2'b00}, // 7  R5 own completion
    {1'b0, 3'd0, 6'b100000, 2'b00}, // 8  R6 store still out
    {1'b0, 3'd0, 6'b001000, 2'b00}, // 9  R6 writeback launched
    {1'b0, 3'd0, 6'b010000, 2'b00}, // 10 R6 writeback still out
    {1'b0, 3'd0, 6'b000000, 2'b00}, // 11 R6 waits on writeback
    {1'b0, 3'd0, 6'b001100, 2'b00}, // 12 R7 inc and dec together
    {1'b0, 3'd0, 6'b000000, 2'b00}, // 13 R7 count still one
    {1'b0, 3'd0, 6'b000100, 2'b00}, // 14 R6 writeback done
    {1'b0, 3'd0, 6'b000000, 2'b01}, // 15 R5 graduation
    {1'b1, 3'd0, 6'b000000, 2'b10}, // 16 R10 marker cleared
    {1'b0, 3'd0, 6'b100000, 2'b00}, // 17 R6 load done
    {1'b0, 3'd0, 6'b000010, 2'b00}, // 18 R10 stray completion
    {1'b1, 3'd2, 6'b000000, 2'b10}, // 19 R2 new maintenance
    {1'b0, 3'd0, 6'b000000, 2'b00}, // 20 R10 stray not remembered
    {1'b0, 3'd0, 6'b000010, 2'b00}, // 21 R5 completion
    {1'b0, 3'd0, 6'b000000, 2'b01}, // 22 R5 graduation
    {1'b1, 3'd1, 6'b000000, 2'b10}, // 23 R10 store after graduation
    {1'b0, 3'd0, 6'b010000, 2'b00}  // 24 R6 store done
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] t, input logic [5:0] ev,
                      input logic eG, input logic eGr, input string tag);
    @(negedge clk);
    reqValid = v; reqType = t;
    {ldDone, stDone, wbStart, wbDone, copDone, flush} = ev;
    #1;
    check(tag, "reqGrant", reqGrant, eG);
    check(tag, "gradAllowed", gradAllowed, eGr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "gradAllowed after reset", gradAllowed, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11], VEC[i][10:8], VEC[i][7:2], VEC[i][1], VEC[i][0],
           $sformatf("vec%0d", i));
    end

    // R8: load count saturates at 3, the fourth load is refused
    for (int i = 0; i < 3; i++) step(1, 3'd0, 6'b000000, 1, 0, "R8 load fill");
    step(1, 3'd0, 6'b000000, 0, 0, "R8 load at max");
    for (int i = 0; i < 4; i++) step(0, 3'd0, 6'b100000, 0, 0, "R8 drain and underflow");
    step(1, 3'd2, 6'b000000, 1, 0, "R8 maintenance");
    step(0, 3'd0, 6'b000010, 0, 0, "R8 completion");
    step(0, 3'd0, 6'b000000, 0, 1, "R8 no underflow wrap");

    // R8: fourth writeback launch ignored at max, two dones leave one
    for (int i = 0; i < 4; i++) step(0, 3'd0, 6'b001000, 0, 0, "R8 wb launch");
    for (int i = 0; i < 2; i++) step(0, 3'd0, 6'b000100, 0, 0, "R8 wb done");
    step(1, 3'd2, 6'b000000, 1, 0, "R8 maintenance");
    step(0, 3'd0, 6'b000010, 0, 0, "R8 completion");
    step(0, 3'd0, 6'b000000, 0, 0, "R8 wb saturated not wrapped");
    step(0, 3'd0, 6'b000100, 0, 0, "R8 last wb done");
    step(0, 3'd0, 6'b000000, 0, 1, "R8 graduation");

    // R9: flush with load, writeback and maintenance outstanding
    step(1, 3'd0, 6'b001000, 1, 0, "R9 load and wb");
    step(1, 3'd2, 6'b000000, 1, 0, "R9 maintenance");
    step(0, 3'd0, 6'b000010, 0, 0, "R9 completion before flush");
    step(1, 3'd0, 6'b000001, 0, 0, "R9 load refused in flush");
    step(1, 3'd2, 6'b000000, 1, 0, "R9 marker cleared by flush");
    step(1, 3'd2, 6'b000001, 0, 0, "R9 maintenance refused in flush");
    step(1, 3'd4, 6'b000001, 1, 0, "R4 fetch passes during flush");
    step(1, 3'd2, 6'b000000, 1, 0, "R9 maintenance again");
    step(0, 3'd0, 6'b000010, 0, 0, "R9 completion");
    step(0, 3'd0, 6'b000000, 0, 0, "R9 wb kept, load cleared");
    step(0, 3'd0, 6'b000100, 0, 0, "R9 wb done");
    step(0, 3'd0, 6'b000000, 0, 1, "R9 graduation");

    // R1: reset in mid-operation returns to idle
    step(1, 3'd2, 6'b000000, 1, 0, "R1 maintenance before reset");
    @(negedge clk);
    rst_n = 1'b0; reqValid = 1'b0;
    {ldDone, stDone, wbStart, wbDone, copDone, flush} = 6'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 3'd0, 6'b000000, 1, 0, "R1 load after reset");

    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule